// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filtering

This block is an asynchronous serial receiver for a bus where several listeners share one line. Each character carries a type bit that marks it as an address frame or a data frame. While the receiver's filter mode is on, it hands only address frames to the logic above and drops data frames without a trace. Once the listener has been selected, filter mode is turned off and every frame comes through until filter mode is switched back on after the last data frame. Filter mode can be written directly. An optional compare against the listener's own address can also switch it, so that a matching address turns filtering off and any other address turns it back on.

The line is taken in through a synchronizer and sampled on a 16x baud tick supplied from outside. Each bit is decided by a majority vote of three samples around the middle of its bit time. The character size runs from 5 to 9 data bits. With 9 bits the ninth bit is the type bit. With fewer bits the type bit sits where the first stop bit would be, and the stop check moves one bit later. The bits of each delivered character appear on a parallel output that holds its value, together with a valid flag that stays up until it is acknowledged and flags for frame type, framing error and overrun.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset, valid_o, ovr_o, ferr_o and filt_mode_o are 0 and data_o is 0.
- R2: size_i selects the character size: code 0..4 gives 5..9 data bits, and codes 5..7 act as 9. Data bits arrive least significant first and land in data_o[0] upward. Bits of data_o above the character size read 0.
- R3: With 9 data bits the ninth bit is the type bit and also appears in data_o[8]. With 5..8 data bits the bit right after the last data bit is the type bit and is not part of data_o. addr_o shows the type bit of the delivered character (1 = address, 0 = data).
- R4: While filter mode is on, a frame with type bit 0 leaves valid_o, data_o and all flags unchanged, and a frame with type bit 1 is delivered.
- R5: While filter mode is off, every completed frame is delivered whatever its type bit.
- R6: A cycle with filt_wr_i high loads filt_val_i into filter mode, shown on filt_mode_o. This takes priority over the address compare.
- R7: With cmp_en_i high, a completed address frame sets filter mode to 0 when data_o[7:0] of that frame equals own_addr_i, and to 1 otherwise. Data frames never change filter mode.
- R8: Each bit takes the majority of three 16x samples around mid-bit, so a disturbance on one sample does not change the bit.
- R9: A start bit that is high again at mid-bit returns the receiver to idle with no frame delivered.
- R10: ferr_o is 1 on a delivered character whose stop position (the bit after the type bit for 5..8 data bits, the bit after the ninth bit for 9) was sampled low. The character is still delivered.
- R11: ovr_o is 1 on a delivered character when the previous character was still valid and not acknowledged in that cycle. A frame that filtering drops never causes an overrun.
- R12: ack_i clears valid_o in the next cycle unless a new character is delivered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idles high |
| tick_i | input | 1 | Strobe at 16 times the bit rate |
| size_i | input | 3 | Character size code (0..4 = 5..9 bits) |
| filt_wr_i | input | 1 | Write strobe for filter mode |
| filt_val_i | input | 1 | Value written into filter mode |
| cmp_en_i | input | 1 | Enables the own-address compare |
| own_addr_i | input | 8 | Own address for the compare |
| ack_i | input | 1 | Acknowledges the held character |
| data_o | output | 9 | Received character bits |
| addr_o | output | 1 | Type bit of the held character |
| valid_o | output | 1 | A character is held and not yet acknowledged |
| ferr_o | output | 1 | Framing error on the held character |
| ovr_o | output | 1 | The held character overwrote an unacknowledged one |
| filt_mode_o | output | 1 | Current filter mode |

## Verification
The hardest case to reach from the ports is a frame that must be dropped while an earlier character is still waiting. Only there can a wrong design overwrite data_o or raise ovr_o. The stimulus delivers one character with filtering off and leaves it unacknowledged, turns filtering on, and sends a data frame. It then checks that the old character, its valid flag and its clear overrun flag are all still in place. The sweep over every character size, both type values and both filter modes, and the own-address sequence that switches filter mode several times, surround that case.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

  localparam int unsigned CHAR_MIN = 5;
  localparam int unsigned CHAR_MAX = 9;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_START,
    FR_PAYLOAD,
    FR_STOP
  } fr_state_e;

  // number of data bits for a size code
  function automatic logic [3:0] char_bits(input logic [2:0] code);
    if (code >= 3'd4) return 4'(CHAR_MAX);
    return 4'(code) + 4'(CHAR_MIN);
  endfunction

  // bits between start and stop: data bits plus a separate type bit when short
  function automatic logic [3:0] payload_bits(input logic [3:0] nbits);
    if (nbits < 4'(CHAR_MAX)) return nbits + 4'd1;
    return nbits;
  endfunction

endpackage

// File: rtl/mdrx_sync.sv
module mdrx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = d_i;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mdrx_sampler.sv
module mdrx_sampler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic active_i,
  output logic bit_stb_o,
  output logic bit_o
);

  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;
  localparam logic [CW-1:0] V_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] V_MID = CW'(MID);
  localparam logic [CW-1:0] V_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] V_TOP = CW'(OVS - 1);
  localparam logic [CW-1:0] V_ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    ones_q, ones_d;
  logic          cnt_en;

  // sample index 0 is the tick that saw the start edge, so a fresh bit starts at 1
  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    if (!active_i) begin
      cnt_d  = V_ONE;
      ones_d = 2'd0;
    end else begin
      cnt_d = (cnt_q == V_TOP) ? '0 : cnt_q + V_ONE;
      if (cnt_q == V_LO)       ones_d = {1'b0, rx_i};
      else if (cnt_q == V_MID) ones_d = ones_q + {1'b0, rx_i};
    end
  end

  assign cnt_en = tick_i | ~active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= V_ONE;
      ones_q <= 2'd0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
    end
  end

  assign bit_stb_o = active_i & tick_i & (cnt_q == V_HI);
  assign bit_o     = (ones_q + {1'b0, rx_i}) >= 2'd2;

endmodule

// File: rtl/mdrx_framer.sv
module mdrx_framer
  import mdrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic [2:0]          size_i,
  input  logic                bit_stb_i,
  input  logic                bit_i,
  output logic                active_o,
  output logic                done_o,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                type_o,
  output logic                ferr_o
);

  fr_state_e           st_q, st_d;
  logic [3:0]          nb_q, nb_d;
  logic [3:0]          len_q, len_d;
  logic [3:0]          idx_q, idx_d;
  logic [CHAR_MAX-1:0] sh_q, sh_d;
  logic                done_d;
  logic [CHAR_MAX-1:0] data_d;
  logic                type_d, ferr_d;
  logic [CHAR_MAX-1:0] keep;

  always_comb begin
    for (int i = 0; i < int'(CHAR_MAX); i++) keep[i] = (4'(i) < nb_q);
  end

  always_comb begin
    st_d   = st_q;
    nb_d   = nb_q;
    len_d  = len_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    data_d = data_o;
    type_d = type_o;
    ferr_d = ferr_o;
    unique case (st_q)
      FR_IDLE: begin
        if (tick_i && !rx_i) begin
          st_d  = FR_START;
          nb_d  = char_bits(size_i);
          len_d = payload_bits(char_bits(size_i));
          idx_d = 4'd0;
          sh_d  = '0;
        end
      end
      FR_START: begin
        if (bit_stb_i) st_d = bit_i ? FR_IDLE : FR_PAYLOAD;
      end
      FR_PAYLOAD: begin
        if (bit_stb_i) begin
          sh_d[idx_q] = bit_i;
          idx_d       = idx_q + 4'd1;
          if (idx_q == len_q - 4'd1) st_d = FR_STOP;
        end
      end
      FR_STOP: begin
        if (bit_stb_i) begin
          done_d = 1'b1;
          data_d = sh_q & keep;
          type_d = sh_q[len_q - 4'd1];
          ferr_d = ~bit_i;
          st_d   = FR_IDLE;
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      nb_q   <= 4'(CHAR_MAX);
      len_q  <= 4'(CHAR_MAX);
      idx_q  <= 4'd0;
      sh_q   <= '0;
      done_o <= 1'b0;
      data_o <= '0;
      type_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      nb_q   <= nb_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      done_o <= done_d;
      data_o <= data_d;
      type_o <= type_d;
      ferr_o <= ferr_d;
    end
  end

  assign active_o = (st_q != FR_IDLE);

endmodule

// File: rtl/mdrx_deliver.sv
module mdrx_deliver
  import mdrx_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_done_i,
  input  logic [CHAR_MAX-1:0] frm_data_i,
  input  logic                frm_type_i,
  input  logic                frm_ferr_i,
  input  logic                ack_i,
  input  logic                filt_wr_i,
  input  logic                filt_val_i,
  input  logic                cmp_en_i,
  input  logic [AW-1:0]       own_addr_i,
  output logic                deliver_o,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                addr_o,
  output logic                valid_o,
  output logic                ferr_o,
  output logic                ovr_o,
  output logic                filt_mode_o
);

  logic mode_d, valid_d, match;

  assign deliver_o = frm_done_i & (~filt_mode_o | frm_type_i);
  assign match     = (frm_data_i[AW-1:0] == own_addr_i);

  always_comb begin
    mode_d = filt_mode_o;
    if (filt_wr_i)                                  mode_d = filt_val_i;
    else if (frm_done_i && frm_type_i && cmp_en_i)  mode_d = ~match;
  end

  always_comb begin
    valid_d = valid_o;
    if (deliver_o)  valid_d = 1'b1;
    else if (ack_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_mode_o <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      filt_mode_o <= mode_d;
      valid_o     <= valid_d;
    end
  end

  // character and its flags load only when a frame is handed over
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      addr_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (deliver_o) begin
      data_o <= frm_data_i;
      addr_o <= frm_type_i;
      ferr_o <= frm_ferr_i;
      ovr_o  <= valid_o & ~ack_i;
    end
  end

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic [2:0]          size_i,
  input  logic                filt_wr_i,
  input  logic                filt_val_i,
  input  logic                cmp_en_i,
  input  logic [ADDR_W-1:0]   own_addr_i,
  input  logic                ack_i,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                addr_o,
  output logic                valid_o,
  output logic                ferr_o,
  output logic                ovr_o,
  output logic                filt_mode_o
);

  logic                rst_sn;
  logic                rx_s;
  logic                active;
  logic                bit_stb, bit_val;
  logic                frm_done, frm_type, frm_ferr;
  logic [CHAR_MAX-1:0] frm_data;
  logic                deliver;

  // reset asserts at once and releases on a clock edge
  mdrx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sn)
  );

  mdrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(rx_i), .q_o(rx_s)
  );

  mdrx_sampler #(.OVS(OVS)) u_sampler (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick_i), .rx_i(rx_s),
    .active_i(active), .bit_stb_o(bit_stb), .bit_o(bit_val)
  );

  mdrx_framer u_framer (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick_i), .rx_i(rx_s), .size_i(size_i),
    .bit_stb_i(bit_stb), .bit_i(bit_val), .active_o(active),
    .done_o(frm_done), .data_o(frm_data), .type_o(frm_type), .ferr_o(frm_ferr)
  );

  mdrx_deliver #(.AW(ADDR_W)) u_deliver (
    .clk(clk), .rst_n(rst_sn),
    .frm_done_i(frm_done), .frm_data_i(frm_data), .frm_type_i(frm_type),
    .frm_ferr_i(frm_ferr), .ack_i(ack_i), .filt_wr_i(filt_wr_i),
    .filt_val_i(filt_val_i), .cmp_en_i(cmp_en_i), .own_addr_i(own_addr_i),
    .deliver_o(deliver), .data_o(data_o), .addr_o(addr_o), .valid_o(valid_o),
    .ferr_o(ferr_o), .ovr_o(ovr_o), .filt_mode_o(filt_mode_o)
  );

endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk
  import mdrx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_i,
  input logic                filt_wr_i,
  input logic                cmp_en_i,
  input logic [ADDR_W-1:0]   own_addr_i,
  input logic                frm_done,
  input logic                frm_type,
  input logic [CHAR_MAX-1:0] frm_data,
  input logic                deliver,
  input logic [CHAR_MAX-1:0] data_o,
  input logic                valid_o,
  input logic                ferr_o,
  input logic                ovr_o,
  input logic                filt_mode_o
);

  assert_drop_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_type && filt_mode_o) |=> $stable(data_o));

  assert_open_delivers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !filt_mode_o) |=> valid_o);

  assert_match_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_type && cmp_en_i && !filt_wr_i &&
     frm_data[ADDR_W-1:0] == own_addr_i) |=> !filt_mode_o);

  assert_ferr_on_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_o) |-> $past(frm_done));

  assert_ovr_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(valid_o));

  assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !deliver) |=> !valid_o);

endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .filt_wr_i(filt_wr_i),
  .cmp_en_i(cmp_en_i), .own_addr_i(own_addr_i), .frm_done(frm_done),
  .frm_type(frm_type), .frm_data(frm_data), .deliver(deliver),
  .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o), .ovr_o(ovr_o),
  .filt_mode_o(filt_mode_o)
);

// File: tb/mdrop_uart_rx_test.sv
module mdrop_uart_rx_test;

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic [2:0] size;
  logic       filt_wr, filt_val, cmp_en, ack;
  logic [7:0] own_addr;
  logic [8:0] data;
  logic       addr, valid, ferr, ovr, fmode;

  int total = 0;
  int bad   = 0;

  mdrop_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .size_i(size),
    .filt_wr_i(filt_wr), .filt_val_i(filt_val), .cmp_en_i(cmp_en),
    .own_addr_i(own_addr), .ack_i(ack), .data_o(data), .addr_o(addr),
    .valid_o(valid), .ferr_o(ferr), .ovr_o(ovr), .filt_mode_o(fmode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // 16x tick on every other clock: one bit time is 32 clocks
  initial tick = 1'b0;
  always @(posedge clk) tick <= ~tick;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    rx = b;
    if (glitch) begin
      repeat (16) @(negedge clk);
      rx = ~b;
      repeat (2) @(negedge clk);
      rx = b;
      repeat (14) @(negedge clk);
    end else begin
      repeat (32) @(negedge clk);
    end
  endtask

  // n data bits; typ goes in the ninth bit or in its own slot; glitch_at = data bit to disturb
  task automatic send(input int n, input logic [8:0] v, input logic typ,
                      input logic stop_ok, input int glitch_at);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = (n == 9 && i == 8) ? typ : v[i];
      drive_bit(b, glitch_at == i);
    end
    if (n < 9) drive_bit(typ, 1'b0);
    drive_bit(stop_ok, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); filt_wr = 1'b1; filt_val = m;
    @(negedge clk); filt_wr = 1'b0;
  endtask

  initial begin
    #(10 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] last;
    rx = 1'b1; size = 3'd3; filt_wr = 1'b0; filt_val = 1'b0;
    cmp_en = 1'b0; own_addr = 8'h5A; ack = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 valid", valid, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 mode", fmode, 0);
    chk("R1 data", data, 0);

    set_mode(1'b1);
    chk("R6 write 1", fmode, 1);
    set_mode(1'b0);
    chk("R6 write 0", fmode, 0);

    // sweep: size codes, patterns, type bit, filter mode
    last = 9'd0;
    for (int code = 0; code < 5; code++) begin
      for (int k = 0; k < 4; k++) begin
        for (int t = 0; t < 2; t++) begin
          for (int m = 0; m < 2; m++) begin
            int n;
            logic [8:0] v, expd, mask;
            n = code + 5;
            mask = 9'((1 << (n > 8 ? 8 : n)) - 1);
            v = 9'((k * 9'h6B + 9'h13 + code * 7) & mask);
            if (k == 3) v = mask;
            expd = (n == 9) ? {t[0], v[7:0]} : v;
            size = code[2:0];
            set_mode(m[0]);
            send(n, v, t[0], 1'b1, -1);
            if (m == 0 || t == 1) begin
              chk(m == 0 ? "R5 delivered" : "R4 address passes", valid, 1);
              chk("R2 data", data, expd);
              chk("R3 type", addr, t);
              chk("R10 no ferr", ferr, 0);
              chk("R11 no ovr", ovr, 0);
              last = expd;
              pulse_ack();
              chk("R12 ack clears", valid, 0);
            end else begin
              chk("R4 dropped no valid", valid, 0);
              chk("R4 dropped data kept", data, last);
            end
          end
        end
      end
    end

    // size codes above 4 behave as 9 bits
    size = 3'd7; set_mode(1'b0);
    send(9, 9'h0A5, 1'b1, 1'b1, -1);
    chk("R2 code7 as 9 bits", data, 9'h1A5);
    pulse_ack();

    // majority vote rejects one disturbed sample
    size = 3'd3;
    send(8, 9'h0FF, 1'b0, 1'b1, 3);
    chk("R8 glitch low", data, 9'h0FF);
    pulse_ack();
    send(8, 9'h000, 1'b0, 1'b1, 5);
    chk("R8 glitch high", data, 9'h000);
    pulse_ack();

    // false start
    @(negedge clk); rx = 1'b0;
    repeat (8) @(negedge clk); rx = 1'b1;
    repeat (96) @(negedge clk);
    chk("R9 false start no frame", valid, 0);
    send(8, 9'h03C, 1'b0, 1'b1, -1);
    chk("R9 recovers", data, 9'h03C);
    pulse_ack();

    // framing error
    send(8, 9'h066, 1'b0, 1'b0, -1);
    chk("R10 bad stop delivered", valid, 1);
    chk("R10 ferr set", ferr, 1);
    chk("R10 data", data, 9'h066);
    pulse_ack();
    size = 3'd4;
    send(9, 9'h0C3, 1'b0, 1'b0, -1);
    chk("R10 ferr 9-bit", ferr, 1);
    pulse_ack();
    size = 3'd3;
    send(8, 9'h011, 1'b0, 1'b1, -1);
    chk("R10 ferr clear", ferr, 0);
    pulse_ack();

    // overrun
    send(8, 9'h021, 1'b0, 1'b1, -1);
    send(8, 9'h042, 1'b0, 1'b1, -1);
    chk("R11 overrun flagged", ovr, 1);
    chk("R11 newest data", data, 9'h042);
    pulse_ack();
    send(8, 9'h077, 1'b0, 1'b1, -1);
    set_mode(1'b1);
    send(8, 9'h099, 1'b0, 1'b1, -1);
    chk("R11 dropped no overrun", ovr, 0);
    chk("R4 pending kept valid", valid, 1);
    chk("R4 pending kept data", data, 9'h077);
    pulse_ack();

    // own-address compare
    cmp_en = 1'b1; own_addr = 8'h5A;
    send(8, 9'h033, 1'b1, 1'b1, -1);
    chk("R7 mismatch keeps filter", fmode, 1);
    chk("R4 address delivered", data, 9'h033);
    pulse_ack();
    send(8, 9'h044, 1'b0, 1'b1, -1);
    chk("R7 data dropped", valid, 0);
    send(8, 9'h05A, 1'b1, 1'b1, -1);
    chk("R7 match opens", fmode, 0);
    pulse_ack();
    send(8, 9'h044, 1'b0, 1'b1, -1);
    chk("R7 data after match", data, 9'h044);
    chk("R7 data no mode change", fmode, 0);
    pulse_ack();
    send(8, 9'h011, 1'b1, 1'b1, -1);
    chk("R7 other address closes", fmode, 1);
    pulse_ack();
    send(8, 9'h022, 1'b0, 1'b1, -1);
    chk("R7 closed drops data", valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule